// File: doc/BRIEF.md
# Programmable Event Counter Bank

This block keeps five 40-bit event counters for a processor core. Two are programmable: each picks one of eight single-bit event lines through its own selector. Each one either counts rising edges of that line (occurrence mode) or counts every cycle the line is high (duration mode). The other three are fixed-function. Each is wired to one dedicated event line and counts the cycles that line is high.

Software configures the bank through a single-cycle write port. One write can load a counter, set up a programmable counter, set the enables and interrupt enables of the fixed counters, or clear overflow status bits. When a counter wraps from all ones to zero, a sticky overflow bit is set. If that counter's interrupt enable is set, the interrupt request line stays high until software clears the bit. All counter values and status bits are driven out of the block as plain outputs.

Top module: `evc_bank`

## Requirements
- R1: Asserting reset clears all counters, the overflow status and every control field, so counters stay at zero after reset until software enables them; the interrupt output is low.
- R2: Write address map: addresses 0 and 1 load programmable counters 0 and 1. Addresses 2 to 4 load fixed counters 0 to 2. Address 5 and 6 hold the controls of programmable counters 0 and 1, with the event select in bits 2:0, mode in bit 3 (0 = occurrence, 1 = duration), enable in bit 4 and interrupt enable in bit 5. Address 7 holds the fixed enables in bits 2:0 and the fixed interrupt enables in bits 5:3. Writing address 8 clears each status bit whose data bit is one. Status bit k and counter slot k in the output bus are ordered as the load addresses.
- R3: In occurrence mode, an enabled programmable counter adds one for each cycle in which its selected event is high and was low in the previous cycle.
- R4: In duration mode, an enabled programmable counter adds one for every cycle its selected event is high.
- R5: A counter whose enable bit is clear holds its value whatever its event does.
- R6: The two programmable counters select their events independently; an event pulse on one counter's selected line leaves the other counter unchanged.
- R7: A software load of a counter takes priority over an increment in the same cycle; the counter then holds exactly the written value.
- R8: A wrap from all ones to zero sets that counter's overflow status bit. The bit stays set until it is cleared through address 8.
- R9: The interrupt output is high exactly while some counter has its overflow status and interrupt enable both set. An overflow with the interrupt enable clear leaves the interrupt low.
- R10: An enabled fixed counter k adds one on every cycle that its dedicated event line k is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 8 | Selectable event lines for the programmable counters |
| fix_evt_i | input | 3 | Dedicated event lines of the fixed counters |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 40 | Register write data |
| cnt_o | output | 200 | All counter values, slot k at bits [40k+39:40k] |
| ovf_o | output | 5 | Sticky overflow status, one bit per counter |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a wrap of a 40-bit counter, since counting up from zero would take about 10^12 cycles. The bench loads a counter one or two steps below all ones and then drives its event for a cycle or two. This brings out the wrap, the sticky status and the interrupt with and without its enable. A load in the same cycle as an active duration event is set up to show that the write wins. A selector switch is used to show that the two programmable counters do not affect each other.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int N_EVT = 8;
  localparam int SEL_W = $clog2(N_EVT);

  typedef enum logic {
    MODE_OCC = 1'b0,
    MODE_DUR = 1'b1
  } cnt_mode_e;

  // control word of a programmable counter, packed LSB first: sel, mode, en, ie
  typedef struct packed {
    logic                 ie;
    logic                 en;
    cnt_mode_e            mode;
    logic [SEL_W-1:0]     sel;
  } pctl_t;

  localparam int PCTL_W = $bits(pctl_t);
endpackage

// File: rtl/evc_evsel.sv
module evc_evsel
  import evc_pkg::*;
(
  input  pctl_t            ctl_i,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] evt_prev_i,
  output logic             step_o
);
  logic lvl, prv;

  always_comb begin
    lvl = evt_i[ctl_i.sel];
    prv = evt_prev_i[ctl_i.sel];
    if (!ctl_i.en)
      step_o = 1'b0;
    else if (ctl_i.mode == MODE_DUR)
      step_o = lvl;
    else
      step_o = lvl & ~prv;
  end
endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  assign cnt_ce = ld_i | step_i;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (step_i) begin
      cnt_d  = cnt_q + W'(1);
      wrap_o = &cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int CNT_W  = 40,
  parameter int N_PROG = 2,
  parameter int N_FIX  = 3,
  parameter int ADDR_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_EVT-1:0]          evt_i,
  input  logic [N_FIX-1:0]          fix_evt_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [CNT_W-1:0]          wr_data_i,
  output logic [(N_PROG+N_FIX)*CNT_W-1:0] cnt_o,
  output logic [N_PROG+N_FIX-1:0]   ovf_o,
  output logic                      irq_o
);
  localparam int N_CNT   = N_PROG + N_FIX;
  localparam int A_PCTL0 = N_CNT;
  localparam int A_FCTL  = N_CNT + N_PROG;
  localparam int A_STAT  = A_FCTL + 1;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_int;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  // previous event levels, shared by the edge detectors
  logic [N_EVT-1:0] evt_q;
  always_ff @(posedge clk_i or negedge rst_int) begin
    if (!rst_int) evt_q <= '0;
    else          evt_q <= evt_i;
  end

  // control registers
  pctl_t            pctl_q [N_PROG];
  pctl_t            pctl_d [N_PROG];
  logic [N_FIX-1:0] fen_q, fen_d, fie_q, fie_d;
  logic             fctl_ce;

  assign fctl_ce = wr_en_i && (wr_addr_i == ADDR_W'(A_FCTL));

  always_comb begin
    for (int k = 0; k < N_PROG; k++) begin
      pctl_d[k] = pctl_q[k];
      if (wr_en_i && (wr_addr_i == ADDR_W'(A_PCTL0 + k)))
        pctl_d[k] = pctl_t'(wr_data_i[PCTL_W-1:0]);
    end
    fen_d = fen_q;
    fie_d = fie_q;
    if (fctl_ce) {fie_d, fen_d} = wr_data_i[2*N_FIX-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_int) begin
    if (!rst_int) begin
      for (int k = 0; k < N_PROG; k++) pctl_q[k] <= '0;
      fen_q <= '0;
      fie_q <= '0;
    end else begin
      for (int k = 0; k < N_PROG; k++) pctl_q[k] <= pctl_d[k];
      if (fctl_ce) begin
        fen_q <= fen_d;
        fie_q <= fie_d;
      end
    end
  end

  // counters
  logic [N_CNT-1:0] ld, wrap, ie_vec;

  for (genvar c = 0; c < N_CNT; c++) begin : g_ld
    assign ld[c] = wr_en_i && (wr_addr_i == ADDR_W'(c));
  end

  for (genvar g = 0; g < N_PROG; g++) begin : g_prog
    logic step;
    evc_evsel u_sel (
      .ctl_i      (pctl_q[g]),
      .evt_i      (evt_i),
      .evt_prev_i (evt_q),
      .step_o     (step)
    );
    evc_counter #(.W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_int),
      .step_i   (step),
      .ld_i     (ld[g]),
      .ld_val_i (wr_data_i),
      .cnt_o    (cnt_o[g*CNT_W +: CNT_W]),
      .wrap_o   (wrap[g])
    );
    assign ie_vec[g] = pctl_q[g].ie;
  end

  for (genvar g = 0; g < N_FIX; g++) begin : g_fix
    logic step;
    assign step = fen_q[g] & fix_evt_i[g];
    evc_counter #(.W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_int),
      .step_i   (step),
      .ld_i     (ld[N_PROG+g]),
      .ld_val_i (wr_data_i),
      .cnt_o    (cnt_o[(N_PROG+g)*CNT_W +: CNT_W]),
      .wrap_o   (wrap[N_PROG+g])
    );
    assign ie_vec[N_PROG+g] = fie_q[g];
  end

  // sticky overflow status, write-one-to-clear; a new wrap wins over a clear
  logic [N_CNT-1:0] ovf_q, ovf_d, clr;

  always_comb begin
    clr   = (wr_en_i && (wr_addr_i == ADDR_W'(A_STAT))) ? wr_data_i[N_CNT-1:0] : '0;
    ovf_d = (ovf_q & ~clr) | wrap;
  end

  always_ff @(posedge clk_i or negedge rst_int) begin
    if (!rst_int) ovf_q <= '0;
    else          ovf_q <= ovf_d;
  end

  assign ovf_o = ovf_q;
  assign irq_o = |(ovf_q & ie_vec);
endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk #(
  parameter int CNT_W  = 40,
  parameter int N_PROG = 2,
  parameter int N_FIX  = 3,
  parameter int ADDR_W = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      fix0_evt_i,
  input logic                      wr_en_i,
  input logic [ADDR_W-1:0]         wr_addr_i,
  input logic [CNT_W-1:0]          wr_data_i,
  input logic [CNT_W-1:0]          cnt_p0_i,
  input logic [CNT_W-1:0]          cnt_f0_i,
  input logic [N_PROG+N_FIX-1:0]   ovf_o,
  input logic                      irq_o
);
  localparam int N_CNT  = N_PROG + N_FIX;
  localparam int A_STAT = N_CNT + N_PROG + 1;

  logic             ld_p0, ld_f0;
  logic [N_CNT-1:0] keep;

  assign ld_p0 = wr_en_i && (wr_addr_i == ADDR_W'(0));
  assign ld_f0 = wr_en_i && (wr_addr_i == ADDR_W'(N_PROG));
  assign keep  = ovf_o & ~((wr_en_i && (wr_addr_i == ADDR_W'(A_STAT))) ? wr_data_i[N_CNT-1:0] : '0);

  // R7: a load lands exactly
  a_r7_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_p0 |=> cnt_p0_i == $past(wr_data_i));

  // R3 / R4: without a load, a counter moves by at most one per cycle
  a_r4_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_p0 |=> (cnt_p0_i == $past(cnt_p0_i)) || (cnt_p0_i == $past(cnt_p0_i) + CNT_W'(1)));

  // R10: fixed counter idle when its event is low
  a_r10_fix_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fix0_evt_i && !ld_f0) |=> $stable(cnt_f0_i));

  // R8: status bits stay set unless cleared
  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ovf_o & $past(keep)) == $past(keep)));

  // R9: no interrupt without a pending overflow
  a_r9_irq_needs_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o == '0) |-> !irq_o);
endmodule

bind evc_bank evc_bank_chk #(
  .CNT_W (CNT_W),
  .N_PROG(N_PROG),
  .N_FIX (N_FIX),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fix0_evt_i (fix_evt_i[0]),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .cnt_p0_i   (cnt_o[CNT_W-1:0]),
  .cnt_f0_i   (cnt_o[N_PROG*CNT_W +: CNT_W]),
  .ovf_o      (ovf_o),
  .irq_o      (irq_o)
);

// File: tb/evc_bank_tb.sv
`timescale 1ns/1ps
module evc_bank_tb;
  localparam int W = 40;
  localparam logic [W-1:0] ONES = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    evt = '0;
  logic [2:0]    fix = '0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [5*W-1:0] cnt;
  logic [4:0]    ovf;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evc_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .fix_evt_i(fix),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cnt_o(cnt), .ovf_o(ovf), .irq_o(irq)
  );

  // stimulus {events, expected occurrence count, expected duration count}
  localparam logic [23:0] VEC [12] = '{
    {8'h01, 8'd0, 8'd0}, {8'h04, 8'd1, 8'd1}, {8'h86, 8'd1, 8'd2},
    {8'h42, 8'd1, 8'd2}, {8'h2C, 8'd2, 8'd3}, {8'h00, 8'd2, 8'd3},
    {8'hFF, 8'd3, 8'd4}, {8'h04, 8'd3, 8'd5}, {8'h14, 8'd3, 8'd6},
    {8'h10, 8'd3, 8'd6}, {8'hF3, 8'd3, 8'd6}, {8'h04, 8'd4, 8'd7}
  };

  function automatic logic [W-1:0] cv(input int k);
    return cnt[k*W +: W];
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 5; k++) chk("R1 reset count", cv(k), '0);
    chk("R1 reset status", W'(ovf), '0);
    chk("R1 reset irq", W'(irq), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 setup: ctrl0 occurrence on evt2, ctrl1 duration on evt2, fixed all enabled
    wr(5, 40'h12);
    wr(6, 40'h1A);
    wr(7, 40'h07);

    // R3 / R4 / R10: table walk
    for (int i = 0; i < 12; i++) begin
      evt = VEC[i][23:16];
      fix = 3'b101;
      @(negedge clk);
      chk("R3 occurrence count", cv(0), W'(VEC[i][15:8]));
      chk("R4 duration count", cv(1), W'(VEC[i][7:0]));
      chk("R10 fixed0 count", cv(2), W'(i + 1));
      chk("R10 fixed1 idle line", cv(3), '0);
      chk("R10 fixed2 count", cv(4), W'(i + 1));
    end
    evt = '0; fix = '0;

    // R5: disabled counters hold
    wr(5, 40'h02);
    wr(7, 40'h00);
    for (int i = 0; i < 4; i++) begin
      evt = (i % 2 == 1) ? 8'h04 : 8'h00;
      fix = 3'b111;
      @(negedge clk);
    end
    evt = '0; fix = '0;
    chk("R5 disabled programmable holds", cv(0), W'(4));
    chk("R5 disabled fixed holds", cv(2), W'(12));
    chk("R4 duration continues", cv(1), W'(9));

    // R6: independent selectors, ctrl0 occurrence on evt5
    wr(5, 40'h15);
    evt = 8'h20;
    @(negedge clk);
    evt = '0;
    @(negedge clk);
    chk("R6 selected counter steps", cv(0), W'(5));
    chk("R6 other counter unchanged", cv(1), W'(9));

    // R7: load beats increment
    evt = 8'h04;
    wr(1, 40'd100);
    chk("R7 load wins", cv(1), W'(100));
    @(negedge clk);
    chk("R7 counts after load", cv(1), W'(101));
    evt = '0;

    // R8 / R9: wrap with interrupt enabled, ctrl0 duration on evt2 with ie
    wr(0, ONES - W'(1));
    wr(5, 40'h3A);
    evt = 8'h04;
    @(negedge clk);
    chk("R8 at all ones", cv(0), ONES);
    chk("R8 no status before wrap", W'(ovf[0]), '0);
    @(negedge clk);
    evt = '0;
    chk("R8 wrapped to zero", cv(0), '0);
    chk("R8 status set", W'(ovf[0]), W'(1));
    chk("R9 irq raised", W'(irq), W'(1));
    @(negedge clk);
    chk("R8 status sticky", W'(ovf[0]), W'(1));
    wr(8, 40'h01);
    chk("R8 status cleared", W'(ovf), '0);
    chk("R9 irq dropped", W'(irq), '0);

    // R9: wrap with interrupt enable clear
    wr(1, ONES);
    evt = 8'h04;
    @(negedge clk);
    evt = '0;
    @(negedge clk);
    chk("R9 status set without ie", W'(ovf[1]), W'(1));
    chk("R9 irq low without ie", W'(irq), '0);
    wr(6, 40'h3A);
    chk("R9 irq on enabling ie", W'(irq), W'(1));

    // R10 / R8: fixed1 wrap
    wr(7, 40'h12);
    wr(3, ONES);
    fix = 3'b010;
    @(negedge clk);
    fix = '0;
    chk("R10 fixed wrap", cv(3), '0);
    chk("R8 fixed status", W'(ovf), W'(5'b01010));
    wr(8, 40'h1F);
    chk("R8 clear all", W'(ovf), '0);
    chk("R9 irq after clear", W'(irq), '0);

    // R1: reset mid-run clears counts and controls
    wr(4, 40'd77);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 async clear", cv(4), '0);
    chk("R1 async clear prog", cv(1), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    evt = 8'hFF; fix = 3'b111;
    repeat (2) @(negedge clk);
    evt = '0; fix = '0;
    for (int k = 0; k < 5; k++) chk("R1 controls cleared", cv(k), '0);

    done = 1'b1;
    summary();
  end
endmodule